// File: doc/BRIEF.md
# Cycle-Counted Sequential Divider

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned or as two's-complement signed numbers, using a shift-and-subtract datapath that retires one quotient bit per clock. A finished operation returns a packed word with the remainder in bits 31:16 and the quotient in bits 15:0. It also returns the negative, zero and overflow condition flags.

Alongside the arithmetic result, the block reports how many processor clock cycles a particular microcoded implementation would spend on the same division. That figure depends on the data. Each quotient step carries its own cost. Early overflow exits are cheaper than full divisions. Sign correction adds a penalty that depends on which operands were negative. The cycle total is scaled by a clock-ratio input, so an emulating system can charge the right amount of time to the rest of the machine.

A one-clock start pulse launches an operation. A one-clock done strobe marks the result, and the outputs then hold until the next accepted start. A zero divisor is reported on a separate output, and the block finishes at once without iterating.

Top module: `seqdiv_top`

## Requirements
- R1: While reset is asserted and after it is released, done_o, div_zero_o, result_o, n_o, z_o, v_o and cycles_o are all zero.
- R2: Unsigned mode (signed_i=0) without overflow returns result_o = {remainder[15:0], quotient[15:0]}, v_o=0, n_o = quotient bit 15, and z_o=1 exactly when the quotient is zero.
- R3: In unsigned mode, if the divisor shifted left by 16 is strictly less than the dividend, the block ends with n_o=1, v_o=1 and z_o=0, returns the dividend unchanged on result_o, and counts 6 cycles.
- R4: A full unsigned division counts 2 cycles, plus 4 for each step forced by the partial remainder's top bit, plus 6 for each other subtracting step, plus 8 for each non-subtracting step. A tail is then added: 6 if the last step was forced, otherwise 4 if the last quotient bit is 1, otherwise 2.
- R5: Signed mode (signed_i=1) without overflow returns the quotient truncated toward zero and a remainder that carries the sign of the dividend, packed as in R2, with the flags computed as in R2.
- R6: In signed mode, if the shifted divisor magnitude is less than or equal to the dividend magnitude, the block ends with n_o=1, v_o=1 and z_o=0, returns the dividend unchanged, and counts 8 cycles, plus 2 if the dividend is negative, plus 4.
- R7: A full signed division counts 8 cycles, plus 2 for a negative dividend, plus 6 for each of the first 15 steps that subtracts and 8 for each that does not, plus a flat 4 for the final step. Sign correction then adds 16 if the divisor is negative, 18 if only the dividend is negative, or 14 if both operands are non-negative.
- R8: A signed quotient outside the 16-bit signed range is reported after the full run, with n_o=1, v_o=1, z_o=0 and the dividend unchanged. The cycle count is the full R7 count.
- R9: cycles_o equals the cycle total multiplied by the clk_ratio_i value captured at start.
- R10: A zero divisor sets div_zero_o=1, returns the dividend unchanged with n_o=z_o=v_o=0 and cycles_o=0, and raises done_o one clock after the start edge.
- R11: done_o is high for exactly one clock. It rises 1 clock after the start edge for an early exit (R3, R6, R10) and 18 clocks after the start edge for a full division.
- R12: start_i is ignored while an operation is in progress. The result of the running operation is unaffected, and no extra done_o pulse appears.
- R13: result_o, flags and cycles_o keep their values after done_o falls, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| signed_i | input | 1 | 1 = signed division, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 16 | Divisor |
| clk_ratio_i | input | 4 | Multiplier applied to the cycle total |
| done_o | output | 1 | One-clock completion strobe |
| div_zero_o | output | 1 | Divisor was zero |
| result_o | output | 32 | {remainder, quotient}, or the dividend on overflow or zero divisor |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| cycles_o | output | 12 | Scaled cycle count |

## Verification
The unsigned division is driven with small quotients, an all-ones quotient, a zero dividend, and a dividend equal to the shifted divisor. It also gets a large dividend whose top bit forces subtraction, which is the only case that exercises the cheaper forced step cost and the forced tail. Signed division is driven with all four sign combinations of dividend and divisor, which separates the three sign-correction penalties and the choice of which of quotient or remainder is negated. The -32768 and +32768 quotient boundaries separate a legal result from a late overflow. Early-exit operands, zero divisors and several clock ratios tell the short paths and the scaling apart from a full run, and starts pulsed mid-operation show whether the busy guard holds.

// File: rtl/seqdiv_pkg.sv
`timescale 1ns/1ps
package seqdiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  // unsigned costs
  localparam int unsigned CU_BASE   = 2;
  localparam int unsigned CU_OVF    = 6;
  localparam int unsigned CU_FORCE  = 4;
  localparam int unsigned CU_SUB    = 6;
  localparam int unsigned CU_SKIP   = 8;
  localparam int unsigned CU_TAIL_F = 6;
  localparam int unsigned CU_TAIL_1 = 4;
  localparam int unsigned CU_TAIL_0 = 2;
  // signed costs
  localparam int unsigned CS_BASE   = 8;
  localparam int unsigned CS_NEG    = 2;
  localparam int unsigned CS_OVF    = 4;
  localparam int unsigned CS_SUB    = 6;
  localparam int unsigned CS_SKIP   = 8;
  localparam int unsigned CS_LAST   = 4;
  localparam int unsigned CS_FIX_DV = 16;
  localparam int unsigned CS_FIX_DD = 18;
  localparam int unsigned CS_FIX_PP = 14;
endpackage

// File: rtl/seqdiv_prep.sv
`timescale 1ns/1ps
module seqdiv_prep import seqdiv_pkg::*; #(
  parameter int VW    = 16,
  parameter int CYC_W = 8,
  localparam int DW   = 2*VW
) (
  input  logic             sgn_i,
  input  logic [DW-1:0]    dvd_i,
  input  logic [VW-1:0]    dvs_i,
  output logic             zero_o,
  output logic             ovf_o,
  output logic [DW-1:0]    rem_o,
  output logic [DW-1:0]    dsh_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             dvd_neg_o,
  output logic             dvs_neg_o
);
  logic [DW-1:0] dsh_raw;

  always_comb begin
    dsh_raw   = {dvs_i, {VW{1'b0}}};
    dvs_neg_o = sgn_i & dsh_raw[DW-1];
    dvd_neg_o = sgn_i & dvd_i[DW-1];
    dsh_o     = dvs_neg_o ? (~dsh_raw + 1'b1) : dsh_raw;
    rem_o     = dvd_neg_o ? (~dvd_i + 1'b1) : dvd_i;
    zero_o    = (dvs_i == '0);
    if (sgn_i) begin
      ovf_o = (dsh_o <= rem_o);
      cyc_o = CYC_W'(CS_BASE)
            + (dvd_neg_o ? CYC_W'(CS_NEG) : '0)
            + (ovf_o ? CYC_W'(CS_OVF) : '0);
    end else begin
      ovf_o = (dsh_raw < dvd_i);
      cyc_o = ovf_o ? CYC_W'(CU_OVF) : CYC_W'(CU_BASE);
    end
  end
endmodule

// File: rtl/seqdiv_step.sv
`timescale 1ns/1ps
module seqdiv_step import seqdiv_pkg::*; #(
  parameter int VW    = 16,
  parameter int CYC_W = 8,
  localparam int DW   = 2*VW
) (
  input  logic             sgn_i,
  input  logic             last_i,
  input  logic [DW-1:0]    rem_i,
  input  logic [DW-1:0]    dsh_i,
  input  logic [VW-1:0]    quo_i,
  input  logic             bit_i,
  output logic [DW-1:0]    rem_o,
  output logic [VW-1:0]    quo_o,
  output logic             bit_o,
  output logic             force_o,
  output logic [CYC_W-1:0] cost_o
);
  logic [DW-1:0] sh;
  logic          take;

  always_comb begin
    force_o = ~sgn_i & rem_i[DW-1];
    sh      = rem_i << 1;
    take    = force_o | (sh >= dsh_i);
    rem_o   = take ? (sh - dsh_i) : sh;
    quo_o   = (quo_i << 1) | VW'(bit_i);
    bit_o   = take;
    if (sgn_i)
      cost_o = last_i ? CYC_W'(CS_LAST) : (take ? CYC_W'(CS_SUB) : CYC_W'(CS_SKIP));
    else
      cost_o = take ? (force_o ? CYC_W'(CU_FORCE) : CYC_W'(CU_SUB)) : CYC_W'(CU_SKIP);
  end
endmodule

// File: rtl/seqdiv_fix.sv
`timescale 1ns/1ps
module seqdiv_fix import seqdiv_pkg::*; #(
  parameter int VW    = 16,
  parameter int CYC_W = 8,
  localparam int DW   = 2*VW
) (
  input  logic             sgn_i,
  input  logic [DW-1:0]    rem_i,
  input  logic [VW-1:0]    quo_i,
  input  logic             bit_i,
  input  logic             force_i,
  input  logic             dvd_neg_i,
  input  logic             dvs_neg_i,
  output logic [DW-1:0]    res_o,
  output logic             ovf_o,
  output logic             n_o,
  output logic             z_o,
  output logic [CYC_W-1:0] cost_o
);
  logic [VW-1:0] qf, qn, q_sel;
  logic [DW-1:0] rn, r_sel;

  always_comb begin
    qf    = (quo_i << 1) | VW'(bit_i);
    qn    = ~qf + 1'b1;
    rn    = ~rem_i + 1'b1;
    q_sel = qf;
    r_sel = rem_i;
    ovf_o = 1'b0;
    if (!sgn_i) begin
      cost_o = force_i ? CYC_W'(CU_TAIL_F) : (bit_i ? CYC_W'(CU_TAIL_1) : CYC_W'(CU_TAIL_0));
    end else if (dvs_neg_i) begin
      cost_o = CYC_W'(CS_FIX_DV);
      if (dvd_neg_i) begin
        if (qf[VW-1]) ovf_o = 1'b1;
        else          r_sel = rn;
      end else begin
        q_sel = qn;
        if (qn != '0 && !qn[VW-1]) ovf_o = 1'b1;
      end
    end else if (dvd_neg_i) begin
      cost_o = CYC_W'(CS_FIX_DD);
      q_sel  = qn;
      if (qn != '0 && !qn[VW-1]) ovf_o = 1'b1;
      else                       r_sel = rn;
    end else begin
      cost_o = CYC_W'(CS_FIX_PP);
      if (qf[VW-1]) ovf_o = 1'b1;
    end
    res_o = r_sel | DW'(q_sel);
    n_o   = q_sel[VW-1];
    z_o   = (q_sel == '0);
  end
endmodule

// File: rtl/seqdiv_top.sv
`timescale 1ns/1ps
module seqdiv_top import seqdiv_pkg::*; #(
  parameter int VW      = 16,
  parameter int CYC_W   = 8,
  parameter int RATIO_W = 4,
  localparam int DW     = 2*VW,
  localparam int OUT_W  = CYC_W + RATIO_W,
  localparam int CNT_W  = $clog2(VW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [DW-1:0]      dividend_i,
  input  logic [VW-1:0]      divisor_i,
  input  logic [RATIO_W-1:0] clk_ratio_i,
  output logic               done_o,
  output logic               div_zero_o,
  output logic [DW-1:0]      result_o,
  output logic               n_o,
  output logic               z_o,
  output logic               v_o,
  output logic [OUT_W-1:0]   cycles_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(VW-1);

  st_e                st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sgn_q, bit_q, force_q, dvd_neg_q, dvs_neg_q;
  logic [DW-1:0]      rem_q, dsh_q, dvd_q;
  logic [VW-1:0]      quo_q;
  logic [CYC_W-1:0]   cyc_q;
  logic [RATIO_W-1:0] ratio_q;

  // prep outputs
  logic             p_zero, p_ovf, p_dvd_neg, p_dvs_neg;
  logic [DW-1:0]    p_rem, p_dsh;
  logic [CYC_W-1:0] p_cyc;
  // step outputs
  logic [DW-1:0]    s_rem;
  logic [VW-1:0]    s_quo;
  logic             s_bit, s_force;
  logic [CYC_W-1:0] s_cost;
  // fix outputs
  logic [DW-1:0]    f_res;
  logic             f_ovf, f_n, f_z;
  logic [CYC_W-1:0] f_cost, f_tot;
  logic [OUT_W-1:0] fast_cyc, full_cyc;

  seqdiv_prep #(.VW(VW), .CYC_W(CYC_W)) u_prep (
    .sgn_i(signed_i), .dvd_i(dividend_i), .dvs_i(divisor_i),
    .zero_o(p_zero), .ovf_o(p_ovf), .rem_o(p_rem), .dsh_o(p_dsh),
    .cyc_o(p_cyc), .dvd_neg_o(p_dvd_neg), .dvs_neg_o(p_dvs_neg)
  );

  seqdiv_step #(.VW(VW), .CYC_W(CYC_W)) u_step (
    .sgn_i(sgn_q), .last_i(cnt_q == LAST), .rem_i(rem_q), .dsh_i(dsh_q),
    .quo_i(quo_q), .bit_i(bit_q), .rem_o(s_rem), .quo_o(s_quo),
    .bit_o(s_bit), .force_o(s_force), .cost_o(s_cost)
  );

  seqdiv_fix #(.VW(VW), .CYC_W(CYC_W)) u_fix (
    .sgn_i(sgn_q), .rem_i(rem_q), .quo_i(quo_q), .bit_i(bit_q),
    .force_i(force_q), .dvd_neg_i(dvd_neg_q), .dvs_neg_i(dvs_neg_q),
    .res_o(f_res), .ovf_o(f_ovf), .n_o(f_n), .z_o(f_z), .cost_o(f_cost)
  );

  always_comb begin
    f_tot    = cyc_q + f_cost;
    fast_cyc = OUT_W'(p_cyc) * OUT_W'(clk_ratio_i);
    full_cyc = OUT_W'(f_tot) * OUT_W'(ratio_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sgn_q      <= 1'b0;
      bit_q      <= 1'b0;
      force_q    <= 1'b0;
      dvd_neg_q  <= 1'b0;
      dvs_neg_q  <= 1'b0;
      rem_q      <= '0;
      dsh_q      <= '0;
      dvd_q      <= '0;
      quo_q      <= '0;
      cyc_q      <= '0;
      ratio_q    <= '0;
      done_o     <= 1'b0;
      div_zero_o <= 1'b0;
      result_o   <= '0;
      n_o        <= 1'b0;
      z_o        <= 1'b0;
      v_o        <= 1'b0;
      cycles_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sgn_q     <= signed_i;
          dvd_q     <= dividend_i;
          ratio_q   <= clk_ratio_i;
          dvd_neg_q <= p_dvd_neg;
          dvs_neg_q <= p_dvs_neg;
          if (p_zero) begin
            done_o     <= 1'b1;
            div_zero_o <= 1'b1;
            result_o   <= dividend_i;
            {n_o, z_o, v_o} <= 3'b000;
            cycles_o   <= '0;
          end else if (p_ovf) begin
            done_o     <= 1'b1;
            div_zero_o <= 1'b0;
            result_o   <= dividend_i;
            {n_o, z_o, v_o} <= 3'b101;
            cycles_o   <= fast_cyc;
          end else begin
            rem_q   <= p_rem;
            dsh_q   <= p_dsh;
            quo_q   <= '0;
            bit_q   <= 1'b0;
            force_q <= 1'b0;
            cyc_q   <= p_cyc;
            cnt_q   <= '0;
            st_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q   <= s_rem;
          quo_q   <= s_quo;
          bit_q   <= s_bit;
          force_q <= s_force;
          cyc_q   <= cyc_q + s_cost;
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == LAST) st_q <= ST_FIN;
        end
        ST_FIN: begin
          done_o     <= 1'b1;
          div_zero_o <= 1'b0;
          cycles_o   <= full_cyc;
          if (f_ovf) begin
            result_o <= dvd_q;
            {n_o, z_o, v_o} <= 3'b101;
          end else begin
            result_o <= f_res;
            n_o <= f_n;
            z_o <= f_z;
            v_o <= 1'b0;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // overflow always reports N set and Z clear (R3, R6, R8)
  a_r3_ovf_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> (n_o && !z_o));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  a_r11_run_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && cnt_q != LAST) |=> (st_q == ST_RUN));

  a_r10_zero_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && divisor_i == '0) |=> (done_o && div_zero_o && cycles_o == '0));

  a_r12_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |=> ($stable(sgn_q) && $stable(dvd_q) && $stable(ratio_q)));

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |=> ($stable(result_o) && $stable(cycles_o) && $stable(v_o)));
endmodule

// File: tb/seqdiv_top_bench.sv
`timescale 1ns/1ps
module seqdiv_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] dvd = '0;
  logic [15:0] dvs = '0;
  logic [3:0]  ratio = 4'd1;
  logic        done, dz, n, z, v;
  logic [31:0] result;
  logic [11:0] cycles;

  typedef struct packed {
    logic [31:0] res;
    logic        n, z, v, dz;
    logic [11:0] cyc;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;

  seqdiv_top u_seqdiv_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dvd), .divisor_i(dvs), .clk_ratio_i(ratio),
    .done_o(done), .div_zero_o(dz), .result_o(result),
    .n_o(n), .z_o(z), .v_o(v), .cycles_o(cycles)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // reference computed from the requirement text
  function automatic exp_t model(input bit s, input logic [31:0] a, input logic [15:0] b,
                                 input logic [3:0] k, output int lat);
    exp_t e;
    logic [31:0] ds, r, da, dsm;
    logic [15:0] q, qq;
    bit f, bt, ovf, dneg, vneg;
    int c;
    e = '0; lat = 18; c = 0;
    ds = {b, 16'h0};
    if (b == 0) begin
      e.res = a; e.dz = 1'b1; lat = 1;
      return e;
    end
    if (!s) begin
      if (ds < a) begin
        e.res = a; e.n = 1; e.v = 1; c = 6; lat = 1;
      end else begin
        r = a; q = 0; bt = 0; f = 0; c = 2;
        for (int i = 0; i < 16; i++) begin
          f = r[31]; q = {q[14:0], bt}; r = r << 1;
          if (f || r >= ds) begin r = r - ds; c += f ? 4 : 6; bt = 1; end
          else begin bt = 0; c += 8; end
        end
        c += f ? 6 : (bt ? 4 : 2);
        q = {q[14:0], bt};
        e.res = {r[31:16], q}; e.n = q[15]; e.z = (q == 0);
      end
    end else begin
      vneg = b[15]; dneg = a[31];
      dsm = vneg ? -ds : ds; da = dneg ? -a : a;
      c = 8 + (dneg ? 2 : 0);
      if (dsm <= da) begin
        c += 4; e.res = a; e.n = 1; e.v = 1; lat = 1;
      end else begin
        r = da; q = 0; bt = 0;
        for (int i = 0; i < 15; i++) begin
          q = {q[14:0], bt}; r = r << 1;
          if (r >= dsm) begin r = r - dsm; c += 6; bt = 1; end
          else begin bt = 0; c += 8; end
        end
        q = {q[14:0], bt}; r = r << 1;
        if (r >= dsm) begin r = r - dsm; q = {q[14:0], 1'b1}; end
        else q = {q[14:0], 1'b0};
        c += 4; ovf = 0;
        if (vneg) begin
          c += 16;
          if (dneg) begin if (q[15]) ovf = 1; else r = -r; end
          else begin qq = -q; q = qq; if (q != 0 && !q[15]) ovf = 1; end
        end else if (dneg) begin
          c += 18; qq = -q; q = qq;
          if (q != 0 && !q[15]) ovf = 1; else r = -r;
        end else begin
          c += 14; if (q[15]) ovf = 1;
        end
        if (ovf) begin e.res = a; e.n = 1; e.v = 1; end
        else begin e.res = {r[31:16], q}; e.n = q[15]; e.z = (q == 0); end
      end
    end
    e.cyc = 12'(c * k);
    return e;
  endfunction

  // monitor: compare every completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R12 unexpected done", 64'(result), 64'(0));
      end else begin
        exp_t  e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(result == e.res, {t, " result"}, 64'(result), 64'(e.res));
        chk({n, z, v} == {e.n, e.z, e.v}, {t, " flags nzv"}, 64'({n, z, v}), 64'({e.n, e.z, e.v}));
        chk(cycles == e.cyc, {t, " cycles"}, 64'(cycles), 64'(e.cyc));
        chk(dz == e.dz, {t, " div_zero"}, 64'(dz), 64'(e.dz));
      end
    end
  end

  task automatic run_op(input bit s, input logic [31:0] a, input logic [15:0] b,
                        input logic [3:0] k, input bit poke, input string tag);
    exp_t e;
    int   lat;
    int   cnt;
    e = model(s, a, b, k, lat);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    sgn = s; dvd = a; dvs = b; ratio = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 40) begin
      if (poke && (cnt == 5 || cnt == 12)) begin
        start = 1'b1; dvs = 16'h0; sgn = ~s; dvd = ~a; ratio = ~k;   // R12 stimulus
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt == lat, {tag, " R11 latency"}, 64'(cnt), 64'(lat));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R11 single pulse"}, 64'(done), 64'(0));
    repeat (2) @(negedge clk);
    chk(result == e.res && cycles == e.cyc && v == e.v, {tag, " R13 hold"},
        64'(result), 64'(e.res));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({done, dz, result, n, z, v, cycles} == '0, "R1 in reset", 64'(result), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, dz, result, n, z, v, cycles} == '0, "R1 after reset", 64'(cycles), 64'(0));

    // unsigned full divisions
    run_op(0, 32'd100, 16'd7, 4'd1, 0, "R2 100/7");
    run_op(0, 32'h0000FFFF, 16'd1, 4'd1, 0, "R2 ffff/1");
    run_op(0, 32'd0, 16'd5, 4'd1, 0, "R2 zero dividend");
    run_op(0, 32'hFFFE0001, 16'hFFFF, 4'd1, 0, "R4 forced steps");
    run_op(0, 32'h00010000, 16'd1, 4'd1, 0, "R4 equal boundary");
    // unsigned early overflow
    run_op(0, 32'h00020000, 16'd1, 4'd1, 0, "R3 overflow");
    run_op(0, 32'hFFFFFFFF, 16'hFFFF, 4'd1, 0, "R3 overflow max");
    // signed, all sign combinations
    run_op(1, 32'd100, 16'd7, 4'd1, 0, "R5 pos/pos R7");
    run_op(1, 32'd100, 16'hFFF9, 4'd1, 0, "R5 pos/neg R7");
    run_op(1, -32'sd100, 16'd7, 4'd1, 0, "R5 neg/pos R7");
    run_op(1, -32'sd100, 16'hFFF9, 4'd1, 0, "R5 neg/neg R7");
    // signed early overflow
    run_op(1, 32'h00010000, 16'd1, 4'd1, 0, "R6 pos overflow");
    run_op(1, 32'hFFFF0000, 16'd1, 4'd1, 0, "R6 neg overflow");
    run_op(1, 32'h80000000, 16'hFFFF, 4'd1, 0, "R6 min dividend");
    // signed quotient range boundaries
    run_op(1, 32'h00008000, 16'd1, 4'd1, 0, "R8 +32768 overflow");
    run_op(1, 32'hFFFF8000, 16'd1, 4'd1, 0, "R8 -32768 legal");
    run_op(1, 32'h00008000, 16'hFFFF, 4'd1, 0, "R8 -32768 by neg divisor");
    run_op(1, 32'hFFFF8000, 16'hFFFF, 4'd1, 0, "R8 both neg overflow");
    // clock ratio scaling
    run_op(0, 32'd12345, 16'd97, 4'd3, 0, "R9 ratio 3");
    run_op(1, -32'sd54321, 16'd123, 4'd15, 0, "R9 ratio 15");
    run_op(0, 32'h00020000, 16'd1, 4'd7, 0, "R9 overflow ratio 7");
    // zero divisor
    run_op(0, 32'd1234, 16'd0, 4'd2, 0, "R10 unsigned");
    run_op(1, 32'hFFFFFFFF, 16'd0, 4'd2, 0, "R10 signed");
    // starts while busy
    run_op(0, 32'd987654, 16'd1000, 4'd1, 1, "R12 busy unsigned");
    run_op(1, -32'sd987, 16'd31, 4'd2, 1, "R12 busy signed");
    // random operands
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a;
      logic [15:0] b;
      bit s;
      s = i[0];
      a = $urandom() >> (i % 17);
      b = 16'($urandom());
      if (b == 0) b = 16'd1;
      if (s) run_op(1, a, b, 4'(1 + i % 4), 0, "R5 random");
      else   run_op(0, a, b, 4'(1 + i % 4), 0, "R2 random");
    end

    repeat (3) @(negedge clk);
    chk(q_exp.size() == 0, "R12 pending results", 64'(q_exp.size()), 64'(0));
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule